// File: doc/BRIEF.md
# Security-Banked Interrupt Target Filter

This block keeps, for every external interrupt, one ownership bit that says whether the interrupt belongs to the secure world (bit clear) or the non-secure world (bit set). It also holds the per-interrupt enable, pending and priority storage. It serves one register bus that carries a security attribute with each request. Every per-interrupt field that the bus can reach passes through a filter. A non-secure accessor sees zero in the fields of secure-owned interrupts, and its writes to those fields have no effect. The ownership bits themselves can be reached only by secure accessors.

Two 4 KB windows decode the same register set. In the main window, the request's own security attribute applies. The alias window gives secure software a way to act as a non-secure accessor, so it can inspect or program exactly what the non-secure side would see. A non-secure request to the alias window is ignored and reads zero. The interrupt-active bits come from outside the block and are only read through the filter. The enable, pending, ownership and priority state drives the block's outputs for the arbitration logic that follows it.

Top module: `irq_secfilter`

## Requirements
- R1: After reset, every ownership bit is 0 (secure). All enable bits, pending bits and priority fields are 0, and `rdata_o` is 0.
- R2: Main-window offset 0x380 + 4·w is an ownership word covering interrupts 32·w to 32·w+31, with bit b belonging to interrupt 32·w+b. A secure access reads it, and a secure write sets bit b to `wdata_i[b]`.
- R3: A non-secure access to an ownership word reads zero, and its write changes no ownership bit.
- R4: Offsets 0x100+4·w and 0x180+4·w (enable) and 0x200+4·w and 0x280+4·w (pending) cover interrupt 32·w+b in bit b. At the first offset of each pair, a 1 in the write data sets the bit. At the second offset, a 1 clears it. A 0 leaves the bit unchanged. Both offsets read the current bits. Read data appears in the cycle after the request and is zero in every other cycle, including after writes.
- R5: For a non-secure access to the enable, pending or active words, each bit whose interrupt is secure-owned reads 0, and a write leaves it unchanged.
- R6: Offset 0x400+4·w is a priority word. Byte lane k (bits 8k+7..8k) belongs to interrupt 4·w+k. Only the top PRIO_BITS bits of each lane are stored, and the lower bits read 0. A non-secure access filters each lane by that lane's interrupt ownership.
- R7: Any field whose interrupt index is at or above NUM_IRQ reads zero, and writes to it are ignored.
- R8: A secure access to the alias window (ALIAS_BASE) behaves exactly as a non-secure access to the main window. A non-secure alias access reads zero and writes nothing. An address outside both windows, at an unmapped offset, or with bits [1:0] nonzero is also ignored and reads zero.
- R9: Offset 0x300+4·w reads `irq_active_i` for interrupts 32·w+b through the ownership filter. Writes to it change nothing.
- R10: A write changes only the fields in byte lanes whose `wstrb_i` bit is 1.
- R11: `irq_en_o`, `irq_pend_o`, `irq_tgt_o` and `irq_prio_o` show the effect of a write from the clock edge that accepts it. Interrupt i takes bits i·PRIO_BITS upward in `irq_prio_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus request, one cycle |
| addr_i | input | 32 | Byte address |
| we_i | input | 1 | 1 = write, 0 = read |
| wstrb_i | input | 4 | Byte-lane write strobes |
| wdata_i | input | 32 | Write data |
| sec_i | input | 1 | 1 = secure accessor |
| rdata_o | output | 32 | Read data, one cycle after the request |
| irq_active_i | input | NUM_IRQ | Active bit per interrupt, from outside |
| irq_en_o | output | NUM_IRQ | Enable bit per interrupt |
| irq_pend_o | output | NUM_IRQ | Pending bit per interrupt |
| irq_tgt_o | output | NUM_IRQ | Ownership bit per interrupt, 1 = non-secure |
| irq_prio_o | output | NUM_IRQ*PRIO_BITS | Stored priority per interrupt |

## Verification
A read request's filtered data is registered once, so it is due exactly one clock after the request and must be zero in the cycle after any write or idle cycle. State outputs change at the edge that accepts the write. The bench drives each request on a falling edge, then drops the request and samples `rdata_o` and all state outputs on the next falling edge, one edge after acceptance. Expected read values are taken from the bench model before the write is applied to it, so each comparison lines up with the single-edge latency.

// File: rtl/isf_pkg.sv
package isf_pkg;

   typedef enum logic [2:0] {
      BK_NONE,
      BK_SETEN,
      BK_CLREN,
      BK_SETPND,
      BK_CLRPND,
      BK_ACT,
      BK_TGT,
      BK_PRIO
   } isf_bank_e;

   localparam int BWORD_W = 5;   // word index inside a 32-interrupt bank
   localparam int PWORD_W = 7;   // word index inside the priority bank
   localparam int LANES   = 4;

endpackage

// File: rtl/isf_decode.sv
module isf_decode
   import isf_pkg::*;
#(
   parameter bit          SEC_EXT    = 1'b1,
   parameter logic [31:0] MAIN_BASE  = 32'hE000_E000,
   parameter logic [31:0] ALIAS_BASE = 32'hE002_E000
) (
   input  logic               req_i,
   input  logic [31:0]        addr_i,
   input  logic               sec_i,
   output logic               hit_o,
   output isf_bank_e          bank_o,
   output logic [BWORD_W-1:0] bword_o,
   output logic [PWORD_W-1:0] pword_o,
   output logic               eff_sec_o
);

   logic        in_main;
   logic        in_alias;
   logic        alias_ok;
   logic [11:0] ofs;

   assign ofs      = addr_i[11:0];
   assign in_main  = (addr_i[31:12] == MAIN_BASE[31:12]);
   assign in_alias = (addr_i[31:12] == ALIAS_BASE[31:12]);

   generate
      if (SEC_EXT) begin : g_secure
         assign alias_ok  = in_alias & sec_i;
         assign eff_sec_o = in_main & sec_i;
      end else begin : g_plain
         assign alias_ok  = 1'b0;
         assign eff_sec_o = 1'b0;
      end
   endgenerate

   always_comb begin
      case (ofs[11:7])
         5'h02:                      bank_o = BK_SETEN;
         5'h03:                      bank_o = BK_CLREN;
         5'h04:                      bank_o = BK_SETPND;
         5'h05:                      bank_o = BK_CLRPND;
         5'h06:                      bank_o = BK_ACT;
         5'h07:                      bank_o = BK_TGT;
         5'h08, 5'h09, 5'h0a, 5'h0b: bank_o = BK_PRIO;
         default:                    bank_o = BK_NONE;
      endcase
   end

   assign hit_o   = req_i & (in_main | alias_ok) & (bank_o != BK_NONE) & (ofs[1:0] == 2'b00);
   assign bword_o = ofs[6:2];
   assign pword_o = ofs[8:2];

endmodule

// File: rtl/isf_lane_mask.sv
module isf_lane_mask
   import isf_pkg::*;
#(
   parameter int NUM_IRQ = 64
) (
   input  isf_bank_e          bank_i,
   input  logic [BWORD_W-1:0] bword_i,
   input  logic [PWORD_W-1:0] pword_i,
   input  logic               eff_sec_i,
   input  logic [NUM_IRQ-1:0] tgt_i,
   output logic [31:0]        allow_o
);

   localparam int NWORD = NUM_IRQ / 32;
   localparam int PWORD = NUM_IRQ / LANES;

   logic [31:0]      tw;
   logic             tw_ok;
   logic [LANES-1:0] pn;
   logic             pn_ok;

   always_comb begin
      tw    = '0;
      tw_ok = 1'b0;
      for (int w = 0; w < NWORD; w++) begin
         if (bword_i == BWORD_W'(w)) begin
            tw    = tgt_i[w*32 +: 32];
            tw_ok = 1'b1;
         end
      end
      pn    = '0;
      pn_ok = 1'b0;
      for (int w = 0; w < PWORD; w++) begin
         if (pword_i == PWORD_W'(w)) begin
            pn    = tgt_i[w*LANES +: LANES];
            pn_ok = 1'b1;
         end
      end
   end

   always_comb begin
      allow_o = '0;
      case (bank_i)
         BK_SETEN, BK_CLREN, BK_SETPND, BK_CLRPND, BK_ACT:
            allow_o = tw_ok ? (eff_sec_i ? '1 : tw) : '0;
         BK_TGT:
            allow_o = (tw_ok && eff_sec_i) ? '1 : '0;
         BK_PRIO:
            for (int k = 0; k < LANES; k++)
               allow_o[k*8 +: 8] = {8{pn_ok & (eff_sec_i | pn[k])}};
         default:
            allow_o = '0;
      endcase
   end

endmodule

// File: rtl/irq_secfilter.sv
module irq_secfilter
   import isf_pkg::*;
#(
   parameter int          NUM_IRQ    = 64,
   parameter int          PRIO_BITS  = 4,
   parameter bit          SEC_EXT    = 1'b1,
   parameter logic [31:0] MAIN_BASE  = 32'hE000_E000,
   parameter logic [31:0] ALIAS_BASE = 32'hE002_E000
) (
   input  logic                         clk_i,
   input  logic                         rst_ni,
   input  logic                         req_i,
   input  logic [31:0]                  addr_i,
   input  logic                         we_i,
   input  logic [3:0]                   wstrb_i,
   input  logic [31:0]                  wdata_i,
   input  logic                         sec_i,
   output logic [31:0]                  rdata_o,
   input  logic [NUM_IRQ-1:0]           irq_active_i,
   output logic [NUM_IRQ-1:0]           irq_en_o,
   output logic [NUM_IRQ-1:0]           irq_pend_o,
   output logic [NUM_IRQ-1:0]           irq_tgt_o,
   output logic [NUM_IRQ*PRIO_BITS-1:0] irq_prio_o
);

   localparam int NWORD  = NUM_IRQ / 32;
   localparam int PWORD  = NUM_IRQ / LANES;
   localparam int PLSB   = 8 - PRIO_BITS;
   localparam int PVEC_W = NUM_IRQ * PRIO_BITS;

   if ((NUM_IRQ % 32) != 0 || NUM_IRQ < 32 || NUM_IRQ > 512) begin : g_bad_num
      $error("irq_secfilter: NUM_IRQ must be a multiple of 32 in 32..512");
   end
   if (PRIO_BITS < 1 || PRIO_BITS > 8) begin : g_bad_prio
      $error("irq_secfilter: PRIO_BITS must be 1..8");
   end
   if (MAIN_BASE[31:12] == ALIAS_BASE[31:12]) begin : g_bad_base
      $error("irq_secfilter: windows must not overlap");
   end

   // ---------------- decode and filter ----------------
   logic               hit;
   isf_bank_e          bank;
   logic [BWORD_W-1:0] bword;
   logic [PWORD_W-1:0] pword;
   logic               eff_sec;
   logic [31:0]        allow;

   isf_decode #(
      .SEC_EXT   (SEC_EXT),
      .MAIN_BASE (MAIN_BASE),
      .ALIAS_BASE(ALIAS_BASE)
   ) u_decode (
      .req_i    (req_i),
      .addr_i   (addr_i),
      .sec_i    (sec_i),
      .hit_o    (hit),
      .bank_o   (bank),
      .bword_o  (bword),
      .pword_o  (pword),
      .eff_sec_o(eff_sec)
   );

   isf_lane_mask #(
      .NUM_IRQ(NUM_IRQ)
   ) u_mask (
      .bank_i   (bank),
      .bword_i  (bword),
      .pword_i  (pword),
      .eff_sec_i(eff_sec),
      .tgt_i    (irq_tgt_o),
      .allow_o  (allow)
   );

   // ---------------- state ----------------
   logic [NUM_IRQ-1:0] en_q,   en_d;
   logic [NUM_IRQ-1:0] pend_q, pend_d;
   logic [NUM_IRQ-1:0] tgt_q,  tgt_d;
   logic [PVEC_W-1:0]  prio_q, prio_d;
   logic [31:0]        rdata_q, rdata_d;

   logic        wr;
   logic [31:0] lane_m;
   logic [31:0] wr_bits;

   assign wr = hit & we_i;

   always_comb begin
      for (int k = 0; k < LANES; k++) lane_m[k*8 +: 8] = {8{wstrb_i[k]}};
   end

   assign wr_bits = wdata_i & allow & lane_m;

   always_comb begin
      en_d   = en_q;
      pend_d = pend_q;
      tgt_d  = tgt_q;
      prio_d = prio_q;
      for (int i = 0; i < NUM_IRQ; i++) begin
         if (wr && bword == BWORD_W'(i / 32)) begin
            if (bank == BK_SETEN  && wr_bits[i % 32]) en_d[i]   = 1'b1;
            if (bank == BK_CLREN  && wr_bits[i % 32]) en_d[i]   = 1'b0;
            if (bank == BK_SETPND && wr_bits[i % 32]) pend_d[i] = 1'b1;
            if (bank == BK_CLRPND && wr_bits[i % 32]) pend_d[i] = 1'b0;
            if (bank == BK_TGT && allow[i % 32] && lane_m[i % 32])
               tgt_d[i] = wdata_i[i % 32];
         end
         if (wr && bank == BK_PRIO && pword == PWORD_W'(i / LANES)
             && allow[(i % LANES) * 8] && wstrb_i[i % LANES])
            prio_d[i*PRIO_BITS +: PRIO_BITS] = wdata_i[(i % LANES)*8 + PLSB +: PRIO_BITS];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q    <= '0;
         pend_q  <= '0;
         prio_q  <= '0;
         rdata_q <= '0;
      end else begin
         en_q    <= en_d;
         pend_q  <= pend_d;
         prio_q  <= prio_d;
         rdata_q <= rdata_d;
      end
   end

   generate
      if (SEC_EXT) begin : g_tgt_store
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) tgt_q <= '0;
            else         tgt_q <= tgt_d;
         end
      end else begin : g_tgt_open
         assign tgt_q = '1;
      end
   endgenerate

   // ---------------- read path ----------------
   logic [31:0] en_w, pd_w, ac_w, tg_w, pr_w, raw;

   always_comb begin
      en_w = '0;
      pd_w = '0;
      ac_w = '0;
      tg_w = '0;
      pr_w = '0;
      for (int w = 0; w < NWORD; w++) begin
         if (bword == BWORD_W'(w)) begin
            en_w = en_q[w*32 +: 32];
            pd_w = pend_q[w*32 +: 32];
            ac_w = irq_active_i[w*32 +: 32];
            tg_w = tgt_q[w*32 +: 32];
         end
      end
      for (int w = 0; w < PWORD; w++) begin
         if (pword == PWORD_W'(w)) begin
            for (int k = 0; k < LANES; k++)
               pr_w[k*8 + 7 -: PRIO_BITS] = prio_q[(w*LANES + k)*PRIO_BITS +: PRIO_BITS];
         end
      end
      case (bank)
         BK_SETEN, BK_CLREN:   raw = en_w;
         BK_SETPND, BK_CLRPND: raw = pd_w;
         BK_ACT:               raw = ac_w;
         BK_TGT:               raw = tg_w;
         BK_PRIO:              raw = pr_w;
         default:              raw = '0;
      endcase
      rdata_d = (hit && !we_i) ? (raw & allow) : '0;
   end

   assign rdata_o    = rdata_q;
   assign irq_en_o   = en_q;
   assign irq_pend_o = pend_q;
   assign irq_tgt_o  = tgt_q;
   assign irq_prio_o = prio_q;

   // ---------------- assertions ----------------
   AST_RDATA_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!req_i || we_i) |=> (rdata_o == '0));                                   // R4

   AST_NS_TGT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i && !eff_sec) |=> $stable(irq_tgt_o));                     // R3

   AST_NS_EN_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && !eff_sec) |=> (((irq_en_o ^ $past(irq_en_o)) & ~$past(irq_tgt_o)) == '0)); // R5

   AST_NS_PEND_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && !eff_sec) |=> (((irq_pend_o ^ $past(irq_pend_o)) & ~$past(irq_tgt_o)) == '0)); // R5

   AST_MISS_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && !hit) |=> ($stable(irq_en_o) && $stable(irq_pend_o)
                           && $stable(irq_tgt_o) && $stable(irq_prio_o) && rdata_o == '0)); // R8

   AST_READ_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && !we_i) |=> ($stable(irq_en_o) && $stable(irq_pend_o)
                            && $stable(irq_tgt_o) && $stable(irq_prio_o)));     // R4

endmodule

// File: tb/irq_secfilter_bench.sv
module irq_secfilter_bench;

   localparam int NI = 64;
   localparam int PB = 4;
   localparam logic [19:0] MAINP  = 20'hE000E;
   localparam logic [19:0] ALIASP = 20'hE002E;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req = 1'b0;
   logic [31:0]     addr = '0;
   logic            we = 1'b0;
   logic [3:0]      wstrb = '0;
   logic [31:0]     wdata = '0;
   logic            sec = 1'b0;
   logic [31:0]     rdata;
   logic [NI-1:0]   act = '0;
   logic [NI-1:0]   en_o, pend_o, tgt_o;
   logic [NI*PB-1:0] prio_o;

   int checks = 0;
   int errors = 0;

   logic [NI-1:0] m_en = '0, m_pend = '0, m_tgt = '0;
   logic [PB-1:0] m_prio [NI];

   always #2 clk = ~clk;

   irq_secfilter #(.NUM_IRQ(NI), .PRIO_BITS(PB)) u_irq_secfilter (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .we_i(we),
      .wstrb_i(wstrb), .wdata_i(wdata), .sec_i(sec), .rdata_o(rdata),
      .irq_active_i(act), .irq_en_o(en_o), .irq_pend_o(pend_o),
      .irq_tgt_o(tgt_o), .irq_prio_o(prio_o)
   );

   task automatic check(input string tag, input logic [255:0] a, input logic [255:0] e);
      checks++;
      if (a !== e) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, a, e);
      end
   endtask

   function automatic logic pass(input int irq, input logic eff);
      if (irq >= NI) return 1'b0;
      return eff | m_tgt[irq];
   endfunction

   function automatic logic valid_of(input logic [31:0] a, input logic sc);
      logic [4:0] bk;
      bk = a[11:7];
      if (a[1:0] != 2'b00) return 1'b0;
      if (bk < 5'd2 || bk > 5'd11) return 1'b0;
      return (a[31:12] == MAINP) || (a[31:12] == ALIASP && sc);
   endfunction

   function automatic logic eff_of(input logic [31:0] a, input logic sc);
      return (a[31:12] == MAINP) && sc;
   endfunction

   function automatic logic [31:0] exp_read(input logic [31:0] a, input logic sc);
      logic [31:0] r;
      logic eff;
      int bk, wb, wp, irq;
      r = '0;
      if (!valid_of(a, sc)) return r;
      eff = eff_of(a, sc);
      bk = int'(a[11:7]);
      wb = int'(a[6:2]);
      wp = int'(a[8:2]);
      if (bk >= 8) begin
         for (int k = 0; k < 4; k++) begin
            irq = wp*4 + k;
            if (pass(irq, eff)) r[k*8 + 8 - PB +: PB] = m_prio[irq];
         end
      end else begin
         for (int b = 0; b < 32; b++) begin
            irq = wb*32 + b;
            if (bk == 7) begin
               if (irq < NI && eff) r[b] = m_tgt[irq];
            end else if (pass(irq, eff)) begin
               case (bk)
                  2, 3:    r[b] = m_en[irq];
                  4, 5:    r[b] = m_pend[irq];
                  default: r[b] = act[irq];
               endcase
            end
         end
      end
      return r;
   endfunction

   task automatic apply_write(input logic [31:0] a, input logic sc, input logic [31:0] d, input logic [3:0] s);
      logic eff;
      int bk, wb, wp, irq;
      if (!valid_of(a, sc)) return;
      eff = eff_of(a, sc);
      bk = int'(a[11:7]);
      wb = int'(a[6:2]);
      wp = int'(a[8:2]);
      if (bk >= 8) begin
         for (int k = 0; k < 4; k++) begin
            irq = wp*4 + k;
            if (pass(irq, eff) && s[k]) m_prio[irq] = d[k*8 + 8 - PB +: PB];
         end
      end else begin
         for (int b = 0; b < 32; b++) begin
            irq = wb*32 + b;
            if (s[b/8]) begin
               if (bk == 7) begin
                  if (irq < NI && eff) m_tgt[irq] = d[b];
               end else if (pass(irq, eff) && d[b]) begin
                  case (bk)
                     2: m_en[irq] = 1'b1;
                     3: m_en[irq] = 1'b0;
                     4: m_pend[irq] = 1'b1;
                     5: m_pend[irq] = 1'b0;
                     default: ;
                  endcase
               end
            end
         end
      end
   endtask

   function automatic string tag_of(input logic [31:0] a, input logic sc);
      int bk;
      bk = int'(a[11:7]);
      if (!valid_of(a, sc) || a[31:12] == ALIASP) return "R8";
      if (bk == 7) return sc ? "R2" : "R3";
      if (bk >= 8) return (int'(a[8:2]) >= NI/4) ? "R7" : "R6";
      if (int'(a[6:2]) >= NI/32) return "R7";
      if (bk == 6) return "R9";
      return sc ? "R4" : "R5";
   endfunction

   task automatic check_state(input string tag);
      logic [NI*PB-1:0] pv;
      for (int i = 0; i < NI; i++) pv[i*PB +: PB] = m_prio[i];
      check({tag, " enable"},  256'(en_o),   256'(m_en));
      check({tag, " pending"}, 256'(pend_o), 256'(m_pend));
      check({tag, " target"},  256'(tgt_o),  256'(m_tgt));
      check({tag, " prio"},    256'(prio_o), 256'(pv));
   endtask

   task automatic op(input logic [31:0] a, input logic w, input logic [31:0] d,
                     input logic [3:0] s, input logic sc, input string stag);
      logic [31:0] e;
      e = w ? 32'h0 : exp_read(a, sc);
      @(negedge clk);
      req = 1'b1; addr = a; we = w; wdata = d; wstrb = s; sec = sc;
      if (w) apply_write(a, sc, d, s);
      @(negedge clk);
      req = 1'b0; we = 1'b0;
      check(tag_of(a, sc), 256'(rdata), 256'(e));
      check_state(stag);
   endtask

   localparam logic [31:0] M = 32'hE000_E000;
   localparam logic [31:0] AL = 32'hE002_E000;

   initial begin
      #(4*150000);
      errors++;
      checks++;
      $display("FAIL R4 watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] rr;
      int unsigned seed;
      for (int i = 0; i < NI; i++) m_prio[i] = '0;
      seed = $urandom(32'd4711);
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 rdata", 256'(rdata), 256'h0);
      check_state("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check_state("R1");

      // R5: everything secure, non-secure set-enable has no effect
      op(M + 32'h100, 1'b1, 32'hFFFF_FFFF, 4'hF, 1'b0, "R5");
      op(M + 32'h100, 1'b0, 32'h0, 4'hF, 1'b0, "R5");
      // R2: secure programs ownership word 0
      op(M + 32'h380, 1'b1, 32'h0000_FFFF, 4'hF, 1'b1, "R2");
      op(M + 32'h380, 1'b0, 32'h0, 4'hF, 1'b1, "R2");
      // R3: non-secure cannot see or change ownership
      op(M + 32'h380, 1'b1, 32'hFFFF_FFFF, 4'hF, 1'b0, "R3");
      op(M + 32'h380, 1'b0, 32'h0, 4'hF, 1'b0, "R3");
      // R5: non-secure sets only its own enables
      op(M + 32'h100, 1'b1, 32'hFFFF_FFFF, 4'hF, 1'b0, "R5");
      op(M + 32'h180, 1'b0, 32'h0, 4'hF, 1'b0, "R5");
      // R10: strobe limits clear to lane 0
      op(M + 32'h180, 1'b1, 32'hFFFF_FFFF, 4'h1, 1'b1, "R10");
      op(M + 32'h100, 1'b0, 32'h0, 4'hF, 1'b1, "R10");
      // R6: priority lanes, non-secure owned then secure owned word
      op(M + 32'h400, 1'b1, 32'hA1B2_C3D4, 4'hF, 1'b0, "R6");
      op(M + 32'h410, 1'b1, 32'hFFFF_FFFF, 4'hF, 1'b0, "R6");
      op(M + 32'h410, 1'b1, 32'h5060_7080, 4'h5, 1'b1, "R6");
      op(M + 32'h410, 1'b0, 32'h0, 4'hF, 1'b0, "R6");
      op(M + 32'h400, 1'b0, 32'h0, 4'hF, 1'b1, "R6");
      // R7: beyond the interrupt count
      op(M + 32'h108, 1'b1, 32'hFFFF_FFFF, 4'hF, 1'b1, "R7");
      op(M + 32'h108, 1'b0, 32'h0, 4'hF, 1'b1, "R7");
      op(M + 32'h440, 1'b1, 32'hFFFF_FFFF, 4'hF, 1'b1, "R7");
      op(M + 32'h388, 1'b1, 32'hFFFF_FFFF, 4'hF, 1'b1, "R7");
      // R8: alias window and stray addresses
      op(AL + 32'h200, 1'b1, 32'hFFFF_FFFF, 4'hF, 1'b1, "R8");
      op(AL + 32'h200, 1'b0, 32'h0, 4'hF, 1'b1, "R8");
      op(AL + 32'h280, 1'b1, 32'hFFFF_FFFF, 4'hF, 1'b0, "R8");
      op(AL + 32'h380, 1'b1, 32'h0, 4'hF, 1'b1, "R8");
      op(M + 32'h101, 1'b1, 32'hFFFF_FFFF, 4'hF, 1'b1, "R8");
      op(32'hE000_F100, 1'b1, 32'hFFFF_FFFF, 4'hF, 1'b1, "R8");
      // R9: active bits read through filter, writes ignored
      act = {32'hDEAD_BEEF, 32'h1234_5678};
      op(M + 32'h300, 1'b0, 32'h0, 4'hF, 1'b0, "R9");
      op(M + 32'h300, 1'b0, 32'h0, 4'hF, 1'b1, "R9");
      op(M + 32'h300, 1'b1, 32'hFFFF_FFFF, 4'hF, 1'b1, "R9");

      // R11: constrained random traffic
      for (int n = 0; n < 800; n++) begin
         logic [31:0] a;
         logic [11:0] base;
         int pick;
         if (n % 25 == 0) act = {$urandom, $urandom};
         pick = int'($urandom % 9);
         case (pick)
            0: base = 12'h100; 1: base = 12'h180; 2: base = 12'h200;
            3: base = 12'h280; 4: base = 12'h300; 5: base = 12'h380;
            6, 7: base = 12'h400;
            default: base = ($urandom % 2 == 0) ? 12'h000 : 12'h600;
         endcase
         if (pick == 6 || pick == 7) a = {20'h0, base + 12'(($urandom % 18) * 4)};
         else a = {20'h0, base + 12'(($urandom % 3) * 4)};
         case ($urandom % 8)
            0:       a[31:12] = ALIASP;
            1:       a[31:12] = 20'hE000F;
            default: a[31:12] = MAINP;
         endcase
         rr = $urandom;
         op(a, 1'($urandom), rr, 4'($urandom), 1'($urandom), "R11");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule